// File: doc/BRIEF.md
# Instruction Fetch Region Protection Unit

This block judges every instruction fetch against four programmable address windows and one catch-all default entry. Each window has a base address, a size picked from a fixed ladder of powers of two, and four attribute bits: an enable, a supervisor-only flag, a guard flag and a compressed-code flag. Windows may overlap. When more than one enabled window covers the fetch address, the one with the lowest index wins. A fetch that no enabled window covers takes its attributes from the default entry.

For each sampled fetch the unit registers the resolved attributes, the index of the winning window and a protection fault flag. A fault is raised for a user-mode fetch into a supervisor-only area, or for a speculative fetch into a guarded area. It is raised only while the processor's protection-enable state bit is set. Software programs the windows through a flat register port with an address, write data and a write strobe. Read data is registered.

Register map (cfg_addr): even address 2*i holds the base of window i. Bits [31:11] are stored and bits [10:0] read as zero. Odd address 2*i+1 holds the attributes of window i: bit 0 enable, bit 1 supervisor-only, bit 2 guarded, bit 3 compressed, bits [12:8] size code. Address 8 is the default entry: bit 1 supervisor-only, bit 2 guarded, bit 3 compressed. All other addresses read as zero and ignore writes.

Top module: `ifetch_guard`

## Requirements
- R1: A window covers a fetch address when the window is enabled and the address bits at and above the window's size shift equal the stored base bits. Base bits below the size shift are ignored.
- R2: Size code 0 selects 2 KB (shift 11). Code c from 1 to 20 selects 2^(c+12) bytes, so code 1 is 8 KB and code 20 is 4 GB. Codes 21 to 31 also act as 4 GB. No 4 KB size exists.
- R3: When several enabled windows cover the address, r_region gives the lowest covering index, and r_hit is 1.
- R4: r_super, r_guard and r_comp carry the attribute bits of the winning window.
- R5: When no enabled window covers the address, r_hit is 0, r_region is 0, and the attributes come from the default entry. A disabled window never covers.
- R6: A user fetch (f_user=1) into a supervisor-only area faults. A supervisor fetch never faults for privilege.
- R7: A speculative fetch (f_spec=1) into a guarded area faults. A non-speculative fetch into a guarded area does not fault.
- R8: While f_prot_en is 0, r_fault stays 0 whatever the attributes are.
- R9: r_valid, r_fault and the attributes appear one clock after the fetch inputs are sampled. When f_valid is 0, r_fault is 0 in the next cycle.
- R10: After synchronous reset, every window is disabled with base 0 and size code 0. The default entry is user-accessible, unguarded and uncompressed. All result outputs are 0.
- R11: cfg_rdata returns, one clock after cfg_addr is sampled, the register contents in the layout above. Writes to unmapped addresses have no effect and those addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Registered configuration read data |
| f_valid | input | 1 | Fetch request valid |
| f_addr | input | 32 | Fetch address |
| f_user | input | 1 | 1 = user-mode fetch, 0 = supervisor |
| f_spec | input | 1 | Fetch is speculative |
| f_prot_en | input | 1 | Protection-enable state bit |
| r_valid | output | 1 | Result valid |
| r_fault | output | 1 | Protection fault for the sampled fetch |
| r_hit | output | 1 | An enabled window covered the fetch |
| r_region | output | 2 | Index of the winning window |
| r_super | output | 1 | Resolved supervisor-only attribute |
| r_guard | output | 1 | Resolved guard attribute |
| r_comp | output | 1 | Resolved compressed attribute |

## Verification
Directed fetches probe the size-ladder edges: the last word of a 2 KB and of an 8 KB window, the first word past each, and an address that a 4 KB window would have excluded. These show whether the shift decode for each size code is right. Overlapping windows with different attribute sets are hit by user and supervisor, speculative and non-speculative fetches, with protection on and off. This tells the priority choice apart from the privilege and guard fault terms. A long random phase rewrites windows, including misaligned bases and out-of-ladder size codes, and aims fetches near the stored bases. A behavioural model compares every output on every clock, so any cycle where the default-entry fallback or the register readback goes wrong is reported.

// File: rtl/ifg_pkg.sv
package ifg_pkg;

  localparam int unsigned MIN_SHIFT = 11;
  localparam int unsigned SZ_W      = 5;

  typedef struct packed {
    logic [SZ_W-1:0] size;
    logic            cmp;
    logic            grd;
    logic            sup;
    logic            en;
  } rgn_attr_t;

  typedef struct packed {
    logic cmp;
    logic grd;
    logic sup;
  } glob_attr_t;

  // number of low address bits a window of this size code ignores
  function automatic int unsigned size_shift(input logic [SZ_W-1:0] code,
                                             input int unsigned aw);
    int unsigned s;
    if (code == '0) s = MIN_SHIFT;
    else            s = int'(code) + MIN_SHIFT + 1;
    if (s > aw) s = aw;
    return s;
  endfunction

endpackage

// File: rtl/ifg_cfg_regs.sv
module ifg_cfg_regs
  import ifg_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_RGN = 4,
  parameter int CA_W    = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cfg_we,
  input  logic [CA_W-1:0]                   cfg_addr,
  input  logic [ADDR_W-1:0]                 cfg_wdata,
  output logic [ADDR_W-1:0]                 cfg_rdata,
  output logic [NUM_RGN-1:0][ADDR_W-1:0]    base_o,
  output rgn_attr_t [NUM_RGN-1:0]           attr_o,
  output glob_attr_t                        glob_o
);

  localparam int GLB_SEL = 2 * NUM_RGN;

  logic             unused_wd;
  logic [ADDR_W-1:0] rd_c;
  glob_attr_t       glob_q;

  assign unused_wd = ^cfg_wdata[7:4];

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
    logic [ADDR_W-1:MIN_SHIFT] base_q;
    rgn_attr_t                 attr_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        base_q <= '0;
        attr_q <= '0;
      end else begin
        if (cfg_we && cfg_addr == CA_W'(2 * g))
          base_q <= cfg_wdata[ADDR_W-1:MIN_SHIFT];
        if (cfg_we && cfg_addr == CA_W'(2 * g + 1)) begin
          attr_q.size <= cfg_wdata[8+SZ_W-1:8];
          attr_q.cmp  <= cfg_wdata[3];
          attr_q.grd  <= cfg_wdata[2];
          attr_q.sup  <= cfg_wdata[1];
          attr_q.en   <= cfg_wdata[0];
        end
      end
    end

    assign base_o[g] = {base_q, {MIN_SHIFT{1'b0}}};
    assign attr_o[g] = attr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      glob_q <= '0;
    end else if (cfg_we && cfg_addr == CA_W'(GLB_SEL)) begin
      glob_q.cmp <= cfg_wdata[3];
      glob_q.grd <= cfg_wdata[2];
      glob_q.sup <= cfg_wdata[1];
    end
  end

  assign glob_o = glob_q;

  always_comb begin
    rd_c = '0;
    for (int i = 0; i < NUM_RGN; i++) begin
      if (cfg_addr == CA_W'(2 * i)) rd_c = base_o[i];
      if (cfg_addr == CA_W'(2 * i + 1)) begin
        rd_c[8+SZ_W-1:8] = attr_o[i].size;
        rd_c[3:0]        = {attr_o[i].cmp, attr_o[i].grd, attr_o[i].sup, attr_o[i].en};
      end
    end
    if (cfg_addr == CA_W'(GLB_SEL))
      rd_c[3:0] = {glob_q.cmp, glob_q.grd, glob_q.sup, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_c;
  end

endmodule

// File: rtl/ifg_rgn_match.sv
module ifg_rgn_match
  import ifg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  rgn_attr_t         attr,
  output logic              hit
);

  int unsigned shift_c;
  logic        diff_c;

  always_comb begin
    shift_c = size_shift(attr.size, ADDR_W);
    diff_c  = 1'b0;
    for (int b = 0; b < ADDR_W; b++) begin
      if (b >= int'(shift_c)) diff_c = diff_c | (addr[b] ^ base[b]);
    end
    hit = attr.en & ~diff_c;
  end

endmodule

// File: rtl/ifg_resolve.sv
module ifg_resolve
  import ifg_pkg::*;
#(
  parameter int NUM_RGN = 4,
  parameter int IDX_W   = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_RGN-1:0]      hit,
  input  rgn_attr_t [NUM_RGN-1:0] attr,
  input  glob_attr_t              glob,
  input  logic                    f_valid,
  input  logic                    f_user,
  input  logic                    f_spec,
  input  logic                    f_prot_en,
  output logic                    r_valid,
  output logic                    r_fault,
  output logic                    r_hit,
  output logic [IDX_W-1:0]        r_region,
  output logic                    r_super,
  output logic                    r_guard,
  output logic                    r_comp
);

  logic             found_c;
  logic [IDX_W-1:0] idx_c;
  glob_attr_t       sel_c;
  logic             fault_c;

  // lowest index has priority: scan downward so it is written last
  always_comb begin
    found_c = 1'b0;
    idx_c   = '0;
    sel_c   = glob;
    for (int i = NUM_RGN - 1; i >= 0; i--) begin
      if (hit[i]) begin
        found_c   = 1'b1;
        idx_c     = IDX_W'(i);
        sel_c.cmp = attr[i].cmp;
        sel_c.grd = attr[i].grd;
        sel_c.sup = attr[i].sup;
      end
    end
    fault_c = f_valid & f_prot_en &
              ((f_user & sel_c.sup) | (f_spec & sel_c.grd));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r_valid  <= 1'b0;
      r_fault  <= 1'b0;
      r_hit    <= 1'b0;
      r_region <= '0;
      r_super  <= 1'b0;
      r_guard  <= 1'b0;
      r_comp   <= 1'b0;
    end else begin
      r_valid  <= f_valid;
      r_fault  <= fault_c;
      r_hit    <= found_c;
      r_region <= idx_c;
      r_super  <= sel_c.sup;
      r_guard  <= sel_c.grd;
      r_comp   <= sel_c.cmp;
    end
  end

endmodule

// File: rtl/ifetch_guard.sv
module ifetch_guard
  import ifg_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_RGN = 4,
  parameter int CA_W    = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic [CA_W-1:0]            cfg_addr,
  input  logic [ADDR_W-1:0]          cfg_wdata,
  output logic [ADDR_W-1:0]          cfg_rdata,
  input  logic                       f_valid,
  input  logic [ADDR_W-1:0]          f_addr,
  input  logic                       f_user,
  input  logic                       f_spec,
  input  logic                       f_prot_en,
  output logic                       r_valid,
  output logic                       r_fault,
  output logic                       r_hit,
  output logic [$clog2(NUM_RGN)-1:0] r_region,
  output logic                       r_super,
  output logic                       r_guard,
  output logic                       r_comp
);

  localparam int IDX_W = $clog2(NUM_RGN);

  logic [NUM_RGN-1:0][ADDR_W-1:0] base_w;
  rgn_attr_t [NUM_RGN-1:0]        attr_w;
  glob_attr_t                     glob_w;
  logic [NUM_RGN-1:0]             hit_w;

  ifg_cfg_regs #(
    .ADDR_W (ADDR_W),
    .NUM_RGN(NUM_RGN),
    .CA_W   (CA_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .base_o   (base_w),
    .attr_o   (attr_w),
    .glob_o   (glob_w)
  );

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_cmp
    ifg_rgn_match #(.ADDR_W(ADDR_W)) u_match (
      .addr(f_addr),
      .base(base_w[g]),
      .attr(attr_w[g]),
      .hit (hit_w[g])
    );
  end

  ifg_resolve #(
    .NUM_RGN(NUM_RGN),
    .IDX_W  (IDX_W)
  ) u_res (
    .clk      (clk),
    .rst      (rst),
    .hit      (hit_w),
    .attr     (attr_w),
    .glob     (glob_w),
    .f_valid  (f_valid),
    .f_user   (f_user),
    .f_spec   (f_spec),
    .f_prot_en(f_prot_en),
    .r_valid  (r_valid),
    .r_fault  (r_fault),
    .r_hit    (r_hit),
    .r_region (r_region),
    .r_super  (r_super),
    .r_guard  (r_guard),
    .r_comp   (r_comp)
  );

endmodule

// File: rtl/ifetch_guard_chk.sv
module ifetch_guard_chk #(
  parameter int NUM_RGN = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       f_valid,
  input logic                       f_user,
  input logic                       f_spec,
  input logic                       f_prot_en,
  input logic                       r_valid,
  input logic                       r_fault,
  input logic                       r_hit,
  input logic [$clog2(NUM_RGN)-1:0] r_region,
  input logic                       r_super,
  input logic                       r_guard
);

  // R6/R7: a fault must have a privilege or a guard cause
  p_fault_cause_r7: assert property (@(posedge clk) disable iff (rst)
    r_fault |-> (($past(f_user) && r_super) || ($past(f_spec) && r_guard)));

  // R6: a non-speculative fault can only come from a user fetch
  p_priv_user_r6: assert property (@(posedge clk) disable iff (rst)
    (r_fault && !$past(f_spec)) |-> $past(f_user));

  p_prot_off_r8: assert property (@(posedge clk) disable iff (rst)
    !f_prot_en |=> !r_fault);

  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !f_valid |=> (!r_fault && !r_valid));

  p_valid_lat_r9: assert property (@(posedge clk) disable iff (rst)
    f_valid |=> r_valid);

  // R5: no hit reports index zero
  p_miss_idx_r5: assert property (@(posedge clk) disable iff (rst)
    !r_hit |-> (r_region == '0));

  p_reset_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!r_hit && !r_fault && !r_valid));

endmodule

bind ifetch_guard ifetch_guard_chk #(.NUM_RGN(NUM_RGN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .f_valid  (f_valid),
  .f_user   (f_user),
  .f_spec   (f_spec),
  .f_prot_en(f_prot_en),
  .r_valid  (r_valid),
  .r_fault  (r_fault),
  .r_hit    (r_hit),
  .r_region (r_region),
  .r_super  (r_super),
  .r_guard  (r_guard)
);

// File: tb/ifetch_guard_bench.sv
module ifetch_guard_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        f_valid = 1'b0;
  logic [31:0] f_addr = '0;
  logic        f_user = 1'b0;
  logic        f_spec = 1'b0;
  logic        f_prot_en = 1'b0;
  logic        r_valid, r_fault, r_hit, r_super, r_guard, r_comp;
  logic [1:0]  r_region;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  ifetch_guard u_ifetch_guard (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .f_valid(f_valid),
    .f_addr(f_addr), .f_user(f_user), .f_spec(f_spec), .f_prot_en(f_prot_en),
    .r_valid(r_valid), .r_fault(r_fault), .r_hit(r_hit), .r_region(r_region),
    .r_super(r_super), .r_guard(r_guard), .r_comp(r_comp)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_base [4];
  bit          m_en [4], m_sup [4], m_grd [4], m_cmp [4];
  int          m_sz [4];
  bit          g_sup, g_grd, g_cmp;
  bit          e_valid, e_fault, e_hit, e_sup, e_grd, e_cmp;
  int          e_idx;
  logic [31:0] e_rdata;
  int          sel;
  bit          a_sup, a_grd, a_cmp;

  function automatic bit covers(int i, logic [31:0] a);
    int sh;
    sh = (m_sz[i] == 0) ? 11 : m_sz[i] + 12;
    if (sh > 32) sh = 32;
    return m_en[i] && ((longint'(a) >> sh) == (longint'(m_base[i]) >> sh));
  endfunction

  function automatic logic [31:0] m_read(logic [3:0] a);
    logic [31:0] v;
    v = '0;
    if (a < 8 && a[0] == 1'b0) v = m_base[a >> 1];
    else if (a < 8) v = (32'(m_sz[a >> 1]) << 8) |
                         {28'd0, m_cmp[a >> 1], m_grd[a >> 1], m_sup[a >> 1], m_en[a >> 1]};
    else if (a == 8) v = {28'd0, g_cmp, g_grd, g_sup, 1'b0};
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin
        m_base[i] = '0; m_en[i] = 0; m_sup[i] = 0; m_grd[i] = 0; m_cmp[i] = 0; m_sz[i] = 0;
      end
      g_sup = 0; g_grd = 0; g_cmp = 0;
      e_valid <= 0; e_fault <= 0; e_hit <= 0; e_idx <= 0;
      e_sup <= 0; e_grd <= 0; e_cmp <= 0; e_rdata <= '0;
    end else begin
      sel = -1;
      for (int i = 3; i >= 0; i--) if (covers(i, f_addr)) sel = i;
      if (sel >= 0) begin a_sup = m_sup[sel]; a_grd = m_grd[sel]; a_cmp = m_cmp[sel]; end
      else          begin a_sup = g_sup;      a_grd = g_grd;      a_cmp = g_cmp;      end
      e_valid <= f_valid;
      e_fault <= f_valid && f_prot_en && ((f_user && a_sup) || (f_spec && a_grd));
      e_hit   <= (sel >= 0);
      e_idx   <= (sel >= 0) ? sel : 0;
      e_sup   <= a_sup; e_grd <= a_grd; e_cmp <= a_cmp;
      e_rdata <= m_read(cfg_addr);
      if (cfg_we) begin
        if (cfg_addr < 8 && cfg_addr[0] == 1'b0)
          m_base[cfg_addr >> 1] = cfg_wdata & 32'hFFFF_F800;
        else if (cfg_addr < 8) begin
          m_en[cfg_addr >> 1]  = cfg_wdata[0];
          m_sup[cfg_addr >> 1] = cfg_wdata[1];
          m_grd[cfg_addr >> 1] = cfg_wdata[2];
          m_cmp[cfg_addr >> 1] = cfg_wdata[3];
          m_sz[cfg_addr >> 1]  = int'(cfg_wdata[12:8]);
        end else if (cfg_addr == 8) begin
          g_sup = cfg_wdata[1]; g_grd = cfg_wdata[2]; g_cmp = cfg_wdata[3];
        end
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(r_valid == e_valid, "R9 valid", 32'(r_valid), 32'(e_valid));
      chk(r_fault == e_fault, "R6 R7 R8 fault", 32'(r_fault), 32'(e_fault));
      chk(r_hit == e_hit, "R1 hit", 32'(r_hit), 32'(e_hit));
      chk(int'(r_region) == e_idx, "R3 region", 32'(r_region), 32'(e_idx));
      chk({r_super, r_guard, r_comp} == {e_sup, e_grd, e_cmp}, "R4 attrs",
          32'({r_super, r_guard, r_comp}), 32'({e_sup, e_grd, e_cmp}));
      chk(cfg_rdata == e_rdata, "R11 rdata", cfg_rdata, e_rdata);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_expect(logic [3:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    chk(cfg_rdata == exp, tag, cfg_rdata, exp);
  endtask

  task automatic fetch(logic [31:0] a, bit u, bit s, bit p, bit v);
    @(negedge clk);
    f_valid = v; f_addr = a; f_user = u; f_spec = s; f_prot_en = p;
    @(negedge clk);
  endtask

  task automatic expect_res(string tag, bit flt, bit hit, int idx, bit cmp);
    chk(r_fault == flt, tag, 32'(r_fault), 32'(flt));
    chk(r_hit == hit, tag, 32'(r_hit), 32'(hit));
    chk(int'(r_region) == idx, tag, 32'(r_region), 32'(idx));
    chk(r_comp == cmp, tag, 32'(r_comp), 32'(cmp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    chk(r_fault == 0 && r_valid == 0 && r_hit == 0, "R10 outputs", 32'({r_fault, r_valid, r_hit}), 0);
    rd_expect(4'd1, 32'h0, "R10 window attr");
    rd_expect(4'd8, 32'h0, "R10 default entry");
    fetch(32'h0000_0900, 1, 1, 1, 1);
    expect_res("R10 no window, no fault", 0, 0, 0, 0);

    // program overlapping windows
    wr(4'd0, 32'h0000_0800); wr(4'd1, 32'h0000_0003);  // 2 KB, super
    wr(4'd2, 32'h0000_0000); wr(4'd3, 32'h0000_010D);  // 8 KB, guard+cmp
    wr(4'd4, 32'h1000_0123); wr(4'd5, 32'h0000_0809);  // 1 MB, cmp
    wr(4'd6, 32'h0000_0000); wr(4'd7, 32'h0000_1402);  // 4 GB, disabled
    rd_expect(4'd4, 32'h1000_0000, "R11 base low bits read zero");
    rd_expect(4'd3, 32'h0000_010D, "R11 attr readback");

    fetch(32'h0000_0900, 1, 0, 1, 1); expect_res("R3 overlap lowest wins, R6 user fault", 1, 1, 0, 0);
    fetch(32'h0000_0900, 0, 1, 1, 1); expect_res("R6 supervisor allowed", 0, 1, 0, 0);
    fetch(32'h0000_07FC, 1, 1, 1, 1); expect_res("R7 speculative guarded", 1, 1, 1, 1);
    fetch(32'h0000_07FC, 1, 0, 1, 1); expect_res("R7 non-speculative guarded ok", 0, 1, 1, 1);
    fetch(32'h0000_1FFC, 1, 0, 1, 1); expect_res("R2 8 KB top edge", 0, 1, 1, 1);
    fetch(32'h0000_0FFC, 1, 0, 1, 1); expect_res("R2 no 4 KB window gap", 1, 1, 0, 0);
    fetch(32'h0000_2000, 1, 1, 1, 1); expect_res("R5 disabled window ignored", 0, 0, 0, 0);
    fetch(32'h100F_FFFC, 1, 1, 1, 1); expect_res("R1 misaligned base ignored", 0, 1, 2, 1);
    fetch(32'h1010_0000, 1, 1, 1, 1); expect_res("R2 past 1 MB", 0, 0, 0, 0);
    fetch(32'h0000_0900, 1, 1, 0, 1); expect_res("R8 protection off", 0, 1, 0, 0);
    wr(4'd7, 32'h0000_1403);
    fetch(32'h8000_0000, 1, 0, 1, 1); expect_res("R2 4 GB window, R6", 1, 1, 3, 0);
    wr(4'd7, 32'h0000_1402);
    wr(4'd8, 32'h0000_0004);
    fetch(32'h0000_2000, 1, 1, 1, 1); expect_res("R5 default guard", 1, 0, 0, 0);
    fetch(32'h0000_2000, 1, 1, 1, 0); expect_res("R9 invalid fetch no fault", 0, 0, 0, 0);
    wr(4'd12, 32'hFFFF_FFFF);
    rd_expect(4'd12, 32'h0, "R11 unmapped write ignored");
    rd_expect(4'd8, 32'h0000_0004, "R11 default entry readback");

    // random phase, model compared every clock
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      cfg_we    = ($urandom % 6) == 0;
      cfg_addr  = 4'($urandom % 16);
      cfg_wdata = $urandom;
      f_valid   = ($urandom % 4) != 0;
      f_user    = $urandom % 2;
      f_spec    = $urandom % 2;
      f_prot_en = ($urandom % 5) != 0;
      if ($urandom % 4 == 0) f_addr = $urandom;
      else f_addr = m_base[$urandom % 4] + ($urandom % 32'h6000) - 32'h1000;
    end
    @(negedge clk);
    cfg_we = 1'b0; f_valid = 1'b0;
    repeat (3) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule